// File: doc/BRIEF.md
# Per-Area External Bus Cycle Sequencer

This block times cycles on an external memory bus whose address space is split into eight equal areas. Every area carries its own settings: an 8-bit or 16-bit data width, a choice of two or three basic states per access, and, for three-state areas only, a count of 0 to 7 programmed waits. A single write port loads these settings. The block also reports whether the bus as a whole runs in 8-bit or 16-bit mode.

A request is a single-clock pulse of `req_i` with an address and a read/write flag, given while the sequencer is idle. The top address bits select the area, and the settings of that area are captured. The sequencer then steps through its states and drives one chip select, the address strobe, the read or write strobe and a done pulse. An external wait input can stretch three-state cycles. Each basic state lasts two clocks, so a strobe can begin in the second half of a state.

Top module: `ext_bus_seq`

## Requirements
- R1: Configuration register 0 (`cfg_sel_i`=0) holds one width bit per area, bit a for area a, where 1 means 16-bit and 0 means 8-bit.
- R2: `mode16_o` is 0 only when every width bit is 0, and 1 when at least one width bit is 1.
- R3: Configuration register 1 holds one access bit per area, bit a for area a, where 1 means three-state and 0 means two-state. A two-state cycle lasts exactly 4 clocks (two states of two clocks each).
- R4: A two-state cycle inserts no wait states, whatever the level of `wait_i`.
- R5: The programmed wait count n of area i sits in bits [3i+2:3i] of register 2 for areas 0 to 3, and in bits [3(i-4)+2:3(i-4)] of register 3 for areas 4 to 7. A three-state cycle with no external wait lasts 6+2n clocks.
- R6: In a three-state cycle, `wait_i` is sampled in the last clock of state two when n=0, and otherwise in the last clock of the last programmed wait. Each sample that finds it high adds one more wait state of 2 clocks, and the next sample falls in that added state's last clock.
- R7: The area is `addr_i[ADDR_W-1:ADDR_W-3]`. `cs_n_o[area]` is low in every clock of the cycle and all other selects stay high. All selects are high for at least one clock between cycles. `bus_addr_o` holds the request address during the cycle.
- R8: `as_n_o` is low from the second clock of a cycle to its last clock. `rd_n_o` follows the same window on reads only.
- R9: `wr_n_o` is low from the third clock of a cycle to its last clock on writes only, and is never low in the first state.
- R10: `done_o` is high for exactly the last clock of each cycle. A request made while a cycle is running is ignored.
- R11: After reset, every area is 16-bit and three-state with 7 programmed waits, so `mode16_o`=1 and a cycle lasts 20 clocks. All strobes and selects are high and `done_o` is low.
- R12: The settings of an area are captured when its request is accepted. A configuration write during a cycle changes only later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Register select: 0 width, 1 access, 2 waits of areas 0-3, 3 waits of areas 4-7 |
| cfg_data_i | input | 12 | Configuration write data |
| req_i | input | 1 | Cycle request, accepted only when idle |
| write_i | input | 1 | 1 for a write cycle, 0 for a read cycle |
| addr_i | input | 24 | Request address |
| wait_i | input | 1 | External wait, active high |
| cs_n_o | output | 8 | Per-area chip selects, active low |
| as_n_o | output | 1 | Address strobe, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| done_o | output | 1 | Last clock of a cycle |
| bus_addr_o | output | 24 | Address of the cycle in progress |
| mode16_o | output | 1 | Global bus mode, 1 means 16-bit |

## Verification
The bench goes after the exact clock where the external wait is sampled. A design that sampled it one wait too early or too late would give a 34-clock cycle a different length, and the clock-by-clock model would report it. Two-state cycles are run with `wait_i` held high, which exposes a design that lets waits leak into short cycles. A request and a wait-count rewrite are injected in the middle of a cycle: a design that did not capture the settings would cut that cycle short, and one that accepted the request would drive a second chip select. Width register patterns of all-zero and a single set bit check the global mode in both directions.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_T1,
      ST_T2,
      ST_TW,
      ST_T3
   } ebs_state_e;
endpackage

// File: rtl/ebs_cfg_regs.sv
module ebs_cfg_regs #(
   parameter int NUM_AREAS = 8,
   parameter int WAIT_W    = 3,
   parameter int CFG_W     = 12
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_i,
   input  logic [1:0]                  sel_i,
   input  logic [CFG_W-1:0]            data_i,
   output logic [NUM_AREAS-1:0]        wide_o,
   output logic [NUM_AREAS-1:0]        three_o,
   output logic [NUM_AREAS*WAIT_W-1:0] waits_o,
   output logic                        mode16_o
);
   localparam int HALF_W = (NUM_AREAS / 2) * WAIT_W;

   if (CFG_W < NUM_AREAS || CFG_W < HALF_W) begin : g_bad_cfg_w
      $error("CFG_W too narrow for the configuration fields");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wide_o  <= '1;
         three_o <= '1;
         waits_o <= '1;
      end else if (wr_i) begin
         case (sel_i)
            2'd0: wide_o  <= data_i[NUM_AREAS-1:0];
            2'd1: three_o <= data_i[NUM_AREAS-1:0];
            2'd2: waits_o[HALF_W-1:0] <= data_i[HALF_W-1:0];
            default: waits_o[2*HALF_W-1:HALF_W] <= data_i[HALF_W-1:0];
         endcase
      end
   end

   assign mode16_o = |wide_o;

   // R2: clearing every width bit drops the global mode to 8-bit
   a_r2_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && sel_i == 2'd0 && data_i[NUM_AREAS-1:0] == '0) |=> !mode16_o);
   // R2: a nonzero width pattern gives 16-bit mode
   a_r2_mode_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && sel_i == 2'd0 && data_i[NUM_AREAS-1:0] != '0) |=> mode16_o);
endmodule

// File: rtl/ebs_area_decode.sv
module ebs_area_decode #(
   parameter int NUM_AREAS = 8,
   parameter int ADDR_W    = 24
) (
   input  logic [ADDR_W-1:0]            addr_i,
   output logic [$clog2(NUM_AREAS)-1:0] idx_o,
   output logic [NUM_AREAS-1:0]         hit_o
);
   localparam int AREA_W = $clog2(NUM_AREAS);

   assign idx_o = addr_i[ADDR_W-1 -: AREA_W];

   for (genvar g = 0; g < NUM_AREAS; g++) begin : g_hit
      assign hit_o[g] = (idx_o == AREA_W'(g));
   end

   // R7: exactly one area matches any address
   always_comb begin
      a_r7_one_hit: assert ($onehot(hit_o) || $isunknown(addr_i));
   end
endmodule

// File: rtl/ebs_seq.sv
module ebs_seq
   import ebs_pkg::*;
#(
   parameter int NUM_AREAS = 8,
   parameter int WAIT_W    = 3,
   parameter int ADDR_W    = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_i,
   input  logic                 write_i,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic [NUM_AREAS-1:0] hit_i,
   input  logic                 three_i,
   input  logic [WAIT_W-1:0]    prog_i,
   input  logic                 wait_i,
   output logic [NUM_AREAS-1:0] cs_n_o,
   output logic                 as_n_o,
   output logic                 rd_n_o,
   output logic                 wr_n_o,
   output logic                 done_o,
   output logic [ADDR_W-1:0]    bus_addr_o
);
   localparam int LEN_W = 8;

   ebs_state_e           state_q;
   logic                 ph_q;
   logic [WAIT_W-1:0]    cnt_q;
   logic [WAIT_W-1:0]    prog_q;
   logic                 three_q;
   logic                 write_q;
   logic [NUM_AREAS-1:0] hit_q;
   logic [LEN_W-1:0]     len_q;
   logic                 active;
   logic                 strobe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         ph_q       <= 1'b0;
         cnt_q      <= '0;
         prog_q     <= '0;
         three_q    <= 1'b0;
         write_q    <= 1'b0;
         hit_q      <= '0;
         bus_addr_o <= '0;
      end else if (state_q == ST_IDLE) begin
         if (req_i) begin
            state_q    <= ST_T1;
            ph_q       <= 1'b0;
            cnt_q      <= '0;
            prog_q     <= prog_i;
            three_q    <= three_i;
            write_q    <= write_i;
            hit_q      <= hit_i;
            bus_addr_o <= addr_i;
         end
      end else if (!ph_q) begin
         ph_q <= 1'b1;
      end else begin
         ph_q <= 1'b0;
         case (state_q)
            ST_T1: state_q <= ST_T2;
            ST_T2: begin
               if (!three_q) begin
                  state_q <= ST_IDLE;
               end else if (prog_q != '0) begin
                  state_q <= ST_TW;
                  cnt_q   <= WAIT_W'(1);
               end else if (wait_i) begin
                  state_q <= ST_TW;
               end else begin
                  state_q <= ST_T3;
               end
            end
            ST_TW: begin
               if (cnt_q < prog_q) begin
                  cnt_q <= cnt_q + WAIT_W'(1);
               end else if (!wait_i) begin
                  state_q <= ST_T3;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign active = (state_q != ST_IDLE);
   assign strobe = active && !(state_q == ST_T1 && !ph_q);
   assign cs_n_o = active ? ~hit_q : '1;
   assign as_n_o = !strobe;
   assign rd_n_o = !(strobe && !write_q);
   assign wr_n_o = !(active && state_q != ST_T1 && write_q);
   assign done_o = ph_q && ((state_q == ST_T2 && !three_q) || state_q == ST_T3);

   // clocks elapsed in the current cycle, used by the length checks
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q <= '0;
      end else if (state_q == ST_IDLE) begin
         len_q <= '0;
      end else if (len_q != '1) begin
         len_q <= len_q + LEN_W'(1);
      end
   end

   // R10: done lasts one clock
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R7: selects rest high for a clock after each cycle
   a_r7_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (cs_n_o == '1));
   // R7: never two selects at once
   a_r7_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n_o));
   // R9: write strobe stays off when the address strobe first falls
   a_r9_no_wr_first: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(as_n_o) |-> wr_n_o);
   // R8 R9: read and write strobes are exclusive
   a_r9_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n_o && !wr_n_o));
   // R3 R4: a two-state cycle ends in its fourth clock
   a_r4_two_state_len: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !three_q) |-> (len_q == LEN_W'(3)));
   // R5: a three-state cycle is at least 6+2n clocks long
   a_r5_three_state_len: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && three_q) |-> (len_q >= LEN_W'(5) + LEN_W'(2) * LEN_W'(prog_q)));
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
   parameter int ADDR_W    = 24,
   parameter int NUM_AREAS = 8,
   parameter int WAIT_W    = 3,
   localparam int AREA_W   = $clog2(NUM_AREAS),
   localparam int HALF_W   = (NUM_AREAS / 2) * WAIT_W,
   localparam int CFG_W    = (NUM_AREAS > HALF_W) ? NUM_AREAS : HALF_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr_i,
   input  logic [1:0]           cfg_sel_i,
   input  logic [CFG_W-1:0]     cfg_data_i,
   input  logic                 req_i,
   input  logic                 write_i,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic                 wait_i,
   output logic [NUM_AREAS-1:0] cs_n_o,
   output logic                 as_n_o,
   output logic                 rd_n_o,
   output logic                 wr_n_o,
   output logic                 done_o,
   output logic [ADDR_W-1:0]    bus_addr_o,
   output logic                 mode16_o
);
   if (NUM_AREAS < 2 || (1 << AREA_W) != NUM_AREAS) begin : g_bad_areas
      $error("NUM_AREAS must be a power of two of at least 2");
   end
   if (ADDR_W <= AREA_W) begin : g_bad_addr
      $error("ADDR_W must exceed the area index width");
   end
   if (WAIT_W < 1) begin : g_bad_wait
      $error("WAIT_W must be at least 1");
   end

   logic [NUM_AREAS-1:0]        wide;
   logic [NUM_AREAS-1:0]        three;
   logic [NUM_AREAS*WAIT_W-1:0] waits;
   logic [AREA_W-1:0]           idx;
   logic [NUM_AREAS-1:0]        hit;
   logic                        unused_wide;

   assign unused_wide = ^wide;

   ebs_cfg_regs #(.NUM_AREAS(NUM_AREAS), .WAIT_W(WAIT_W), .CFG_W(CFG_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (cfg_wr_i),
      .sel_i    (cfg_sel_i),
      .data_i   (cfg_data_i),
      .wide_o   (wide),
      .three_o  (three),
      .waits_o  (waits),
      .mode16_o (mode16_o)
   );

   ebs_area_decode #(.NUM_AREAS(NUM_AREAS), .ADDR_W(ADDR_W)) u_dec (
      .addr_i (addr_i),
      .idx_o  (idx),
      .hit_o  (hit)
   );

   ebs_seq #(.NUM_AREAS(NUM_AREAS), .WAIT_W(WAIT_W), .ADDR_W(ADDR_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req_i),
      .write_i    (write_i),
      .addr_i     (addr_i),
      .hit_i      (hit),
      .three_i    (three[idx]),
      .prog_i     (waits[idx*WAIT_W +: WAIT_W]),
      .wait_i     (wait_i),
      .cs_n_o     (cs_n_o),
      .as_n_o     (as_n_o),
      .rd_n_o     (rd_n_o),
      .wr_n_o     (wr_n_o),
      .done_o     (done_o),
      .bus_addr_o (bus_addr_o)
   );

   // R7: the cycle address stays put while a select is low
   a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n_o != '1 && $past(cs_n_o) != '1) |-> $stable(bus_addr_o));
endmodule

// File: tb/ext_bus_seq_test.sv
module ext_bus_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_i = 1'b0;
   logic [1:0]  cfg_sel_i = '0;
   logic [11:0] cfg_data_i = '0;
   logic        req_i = 1'b0;
   logic        write_i = 1'b0;
   logic [23:0] addr_i = '0;
   logic        wait_i = 1'b0;
   logic [7:0]  cs_n_o;
   logic        as_n_o, rd_n_o, wr_n_o, done_o, mode16_o;
   logic [23:0] bus_addr_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // bench-side view of the configuration for length expectations
   bit t_three [8];
   int t_wait  [8];

   // reference model state
   bit m_wide [8];
   bit m_three [8];
   int m_wait [8];
   bit m_busy;
   int m_k, m_e, m_n, m_area;
   bit m_three_c, m_wr_c;
   logic [23:0] m_addr;

   ext_bus_seq uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr_i), .cfg_sel_i(cfg_sel_i),
      .cfg_data_i(cfg_data_i), .req_i(req_i), .write_i(write_i), .addr_i(addr_i),
      .wait_i(wait_i), .cs_n_o(cs_n_o), .as_n_o(as_n_o), .rd_n_o(rd_n_o),
      .wr_n_o(wr_n_o), .done_o(done_o), .bus_addr_o(bus_addr_o), .mode16_o(mode16_o)
   );

   always #2 clk = ~clk;

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int m_len();
      return m_three_c ? 6 + 2 * m_n + 2 * m_e : 4;
   endfunction

   // model advances on the same edge as the design
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) begin
            m_wide[i] = 1'b1; m_three[i] = 1'b1; m_wait[i] = 7;
         end
         m_busy = 1'b0; m_k = 0; m_e = 0;
      end else begin
         if (!m_busy) begin
            if (req_i) begin
               m_busy = 1'b1; m_k = 0; m_e = 0;
               m_area = int'(addr_i[23:21]);
               m_three_c = m_three[m_area];
               m_n = m_wait[m_area];
               m_wr_c = write_i;
               m_addr = addr_i;
            end
         end else if (m_k == m_len() - 1) begin
            m_busy = 1'b0;
         end else begin
            if (m_three_c && m_k == 3 + 2 * m_n + 2 * m_e && wait_i) m_e++;
            m_k++;
         end
         if (cfg_wr_i) begin
            for (int i = 0; i < 8; i++) begin
               case (cfg_sel_i)
                  2'd0: m_wide[i] = cfg_data_i[i];
                  2'd1: m_three[i] = cfg_data_i[i];
                  2'd2: if (i < 4) m_wait[i] = int'(cfg_data_i[3*i +: 3]);
                  default: if (i >= 4) m_wait[i] = int'(cfg_data_i[3*(i-4) +: 3]);
               endcase
            end
         end
      end
   end

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         logic [7:0] e_cs;
         bit any_wide;
         any_wide = 1'b0;
         for (int i = 0; i < 8; i++) any_wide |= m_wide[i];
         e_cs = m_busy ? ~(8'd1 << m_area) : 8'hFF;
         check("R7 cs_n", int'(cs_n_o), int'(e_cs));
         check("R8 as_n", int'(as_n_o), int'(!(m_busy && m_k >= 1)));
         check("R8 rd_n", int'(rd_n_o), int'(!(m_busy && m_k >= 1 && !m_wr_c)));
         check("R9 wr_n", int'(wr_n_o), int'(!(m_busy && m_k >= 2 && m_wr_c)));
         check("R10 done", int'(done_o), int'(m_busy && m_k == m_len() - 1));
         check("R2 mode16", int'(mode16_o), int'(any_wide));
         if (m_busy) check("R7 bus_addr", int'(bus_addr_o), int'(m_addr));
      end
   end

   function automatic int exp_len(input int area, input int wclk);
      int e;
      if (!t_three[area]) return 4;
      e = 0;
      while (3 + 2 * t_wait[area] + 2 * e < wclk) e++;
      return 6 + 2 * t_wait[area] + 2 * e;
   endfunction

   task automatic cfg_write(input int sel, input logic [11:0] data);
      cfg_wr_i = 1'b1; cfg_sel_i = 2'(sel); cfg_data_i = data;
      @(negedge clk);
      cfg_wr_i = 1'b0;
      for (int i = 0; i < 8; i++) begin
         if (sel == 1) t_three[i] = data[i];
         if (sel == 2 && i < 4) t_wait[i] = int'(data[3*i +: 3]);
         if (sel == 3 && i >= 4) t_wait[i] = int'(data[3*(i-4) +: 3]);
      end
   endtask

   // one cycle; wait_i high for the first wclk clocks; poke injects a
   // request and a wait rewrite of area 5 in the third clock
   task automatic run_cycle(input string tag, input int area, input bit wr,
                            input int wclk, input bit poke);
      int c, exp;
      exp = exp_len(area, wclk);
      req_i = 1'b1; write_i = wr; addr_i = {3'(area), 21'h0A5C3 + 21'(area)};
      @(negedge clk);
      req_i = 1'b0;
      c = 0;
      forever begin
         wait_i = (c < wclk);
         req_i = poke && c == 2;
         cfg_wr_i = poke && c == 2;
         if (poke && c == 2) begin
            addr_i = 24'h012345; cfg_sel_i = 2'd3; cfg_data_i = 12'h3C0;
         end
         if (done_o || c > 300) break;
         @(negedge clk);
         c++;
      end
      req_i = 1'b0; cfg_wr_i = 1'b0; wait_i = 1'b0;
      if (poke) t_wait[5] = 0;
      check(tag, c + 1, exp);
      @(negedge clk);
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         finished = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) begin t_three[i] = 1'b1; t_wait[i] = 7; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      check("R11 reset cs_n", int'(cs_n_o), 255);
      check("R11 reset strobes", int'({as_n_o, rd_n_o, wr_n_o}), 7);
      check("R11 reset done", int'(done_o), 0);
      check("R11 reset mode16", int'(mode16_o), 1);
      run_cycle("R11 default length", 0, 1'b0, 0, 1'b0);
      run_cycle("R11 default write length", 3, 1'b1, 0, 1'b0);

      cfg_write(1, 12'h0F0);
      cfg_write(2, 12'h0D1);  // area0=1 area1=2 area2=3 area3=0
      cfg_write(3, 12'h3D0);  // area4=0 area5=2 area6=7 area7=1
      run_cycle("R3 two-state read", 1, 1'b0, 0, 1'b0);
      run_cycle("R4 two-state ignores wait", 1, 1'b0, 10, 1'b0);
      run_cycle("R4 two-state write with wait", 2, 1'b1, 10, 1'b0);
      run_cycle("R5 n0 read", 4, 1'b0, 0, 1'b0);
      run_cycle("R6 n0 one external wait", 4, 1'b0, 4, 1'b0);
      run_cycle("R6 wait released before sample", 4, 1'b1, 3, 1'b0);
      run_cycle("R6 n2 write one external wait", 5, 1'b1, 8, 1'b0);
      run_cycle("R5 n7 read", 6, 1'b0, 0, 1'b0);
      run_cycle("R6 n1 long external wait", 7, 1'b1, 30, 1'b0);

      cfg_write(0, 12'h000);
      check("R1 all narrow mode16", int'(mode16_o), 0);
      cfg_write(0, 12'h008);
      check("R1 one wide area mode16", int'(mode16_o), 1);

      run_cycle("R12 mid-cycle rewrite ignored", 5, 1'b0, 0, 1'b1);
      run_cycle("R12 rewrite applies next cycle", 5, 1'b0, 0, 1'b0);
      run_cycle("R10 after ignored request", 0, 1'b1, 0, 1'b0);

      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule